// File: doc/BRIEF.md
# Register Rename Unit with Squash Recovery

This block sits in the in-order front end of an out-of-order core. It translates each instruction's architectural register names into physical register tags drawn from a larger pool. Because every write gets a fresh physical register, write-after-read and write-after-write hazards on architectural names disappear. Downstream logic then waits only on true data dependences.

The unit holds three things: an alias table with one physical tag per architectural register, a bitmap of free physical registers, and a recovery history. The history keeps one entry per in-flight instruction and records the displaced mapping. A commit retires the oldest history entry and releases the physical register that instruction displaced. A flush walks the history from youngest to oldest, one entry per cycle. At each step it puts back the old mapping and releases the register that had been handed out. Each renamed instruction appears on the output one cycle after it is accepted. The output carries the translated sources, the new destination tag and the displaced tag, which the reorder buffer can keep.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are free. `in_ready` is 1 and `out_valid` is 0.
- R2: Sources are translated through the table as it stood before this instruction's destination is remapped. An instruction that reads and writes the same register sees the old tag.
- R3: An accepted instruction with a destination takes the lowest-numbered free physical register. One cycle after acceptance, `out_valid` is 1 and `out_dst_p` holds the new tag. `out_old_p` holds the tag that the destination mapped to before.
- R4: A later instruction that reads a renamed architectural register gets the newest tag.
- R5: An instruction with `in_has_dst`=0 takes no physical register. `out_has_dst` and `out_dst_p` are 0, and the free set is unchanged.
- R6: When no physical register is free, `in_ready` is 0 for an instruction with a destination. It stays 1 for one without a destination.
- R7: `commit_valid` retires the oldest history entry. If that entry had a destination, its displaced tag becomes free. A commit with an empty history has no effect.
- R8: `flush_valid` discards every history entry, youngest first, one per cycle. Each discarded entry restores its old mapping and frees its new tag. `in_ready` is 0 in the flush cycle and for the rest of the walk. `commit_valid` is ignored in the flush cycle and during the walk.
- R9: A register freed by a commit in a given cycle cannot be allocated in that same cycle. It can be allocated from the next cycle on.
- R10: When the history holds HIST_DEPTH entries, `in_ready` is 0 even for an instruction with no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | AW | Architectural destination |
| in_src1 | input | AW | Architectural source 1 |
| in_src2 | input | AW | Architectural source 2 |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| commit_valid | input | 1 | Retire the oldest in-flight instruction |
| flush_valid | input | 1 | Squash all in-flight instructions |
| out_valid | output | 1 | Renamed instruction present |
| out_has_dst | output | 1 | Renamed instruction has a destination |
| out_src1_p | output | PW | Physical source 1 |
| out_src2_p | output | PW | Physical source 2 |
| out_dst_p | output | PW | New physical destination |
| out_old_p | output | PW | Displaced physical destination |

## Verification
Two functions can fall in the same cycle: a commit that frees a register, and a rename that wants one. The bench drains the free list completely, then raises a commit together with a renaming request that has a destination. It expects `in_ready` to stay low in that cycle and the freed tag to be granted on the very next cycle. Random traffic also mixes commits with renames in the same cycle throughout. Every output is compared with a bench model of the table, free set and history.

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_has_dst,
  input  logic [$clog2(NUM_ARCH)-1:0] in_dst,
  input  logic [$clog2(NUM_ARCH)-1:0] in_src1,
  input  logic [$clog2(NUM_ARCH)-1:0] in_src2,
  output logic                        in_ready,
  input  logic                        commit_valid,
  input  logic                        flush_valid,
  output logic                        out_valid,
  output logic                        out_has_dst,
  output logic [$clog2(NUM_PHYS)-1:0] out_src1_p,
  output logic [$clog2(NUM_PHYS)-1:0] out_src2_p,
  output logic [$clog2(NUM_PHYS)-1:0] out_dst_p,
  output logic [$clog2(NUM_PHYS)-1:0] out_old_p
);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int PW = $clog2(NUM_PHYS);
  localparam int HW = $clog2(HIST_DEPTH);
  localparam int CW = HW + 1;

  logic [PW-1:0]       rat [NUM_ARCH];
  logic [NUM_PHYS-1:0] free_map;

  logic          h_dst  [HIST_DEPTH];
  logic [AW-1:0] h_arch [HIST_DEPTH];
  logic [PW-1:0] h_new  [HIST_DEPTH];
  logic [PW-1:0] h_old  [HIST_DEPTH];
  logic [HW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          flushing;

  logic [PW-1:0] pick;
  logic          have_free;

  always_comb begin
    pick = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--)
      if (free_map[i]) pick = PW'(i);
  end

  assign have_free = |free_map;

  logic          hist_full, accept, alloc, do_commit, walk;
  logic [HW-1:0] ytail;

  assign hist_full = (cnt == CW'(HIST_DEPTH));
  assign in_ready  = !flushing && !flush_valid && !hist_full && (!in_has_dst || have_free);
  assign accept    = in_valid && in_ready;
  assign alloc     = accept && in_has_dst;
  assign do_commit = commit_valid && !flushing && !flush_valid && (cnt != '0);
  assign walk      = flushing && (cnt != '0);
  assign ytail     = tail - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) rat[i] <= PW'(i);
    end else if (alloc) begin
      rat[in_dst] <= pick;
    end else if (walk && h_dst[ytail]) begin
      rat[h_arch[ytail]] <= h_old[ytail];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) free_map[i] <= (i >= NUM_ARCH);
    end else begin
      if (alloc) free_map[pick] <= 1'b0;
      if (do_commit && h_dst[head]) free_map[h_old[head]] <= 1'b1;
      if (walk && h_dst[ytail]) free_map[h_new[ytail]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      h_dst[tail]  <= in_has_dst;
      h_arch[tail] <= in_dst;
      h_new[tail]  <= pick;
      h_old[tail]  <= rat[in_dst];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      flushing <= 1'b0;
    end else begin
      if (accept) tail <= tail + 1'b1;
      else if (walk) tail <= ytail;
      if (do_commit) head <= head + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(do_commit) - CW'(walk);
      if (flush_valid) flushing <= 1'b1;
      else if (flushing && cnt == '0) flushing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_has_dst <= 1'b0;
      out_src1_p  <= '0;
      out_src2_p  <= '0;
      out_dst_p   <= '0;
      out_old_p   <= '0;
    end else begin
      out_valid   <= accept;
      out_has_dst <= alloc;
      out_src1_p  <= rat[in_src1];
      out_src2_p  <= rat[in_src2];
      out_dst_p   <= alloc ? pick : '0;
      out_old_p   <= alloc ? rat[in_dst] : '0;
    end
  end

  // R3: a freshly granted tag is no longer in the free set
  a_r3_dst_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_has_dst |-> !free_map[out_dst_p]);

  // R5: output only follows an accepted request
  a_r5_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R6: no grant of a destination while the free set is empty
  a_r6_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (free_map == '0) && in_has_dst |-> !in_ready);

  // R8: the walk blocks new instructions
  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !in_ready);

  // R8: after the walk the history is empty
  a_r8_walk_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> cnt == '0);

  // R10: history occupancy never exceeds its depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HIST_DEPTH));
endmodule

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
  localparam int NA = 8, NP = 16, HD = 16;
  localparam int AW = $clog2(NA), PW = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_dst = 0, commit_valid = 0, flush_valid = 0;
  logic [AW-1:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic in_ready, out_valid, out_has_dst;
  logic [PW-1:0] out_src1_p, out_src2_p, out_dst_p, out_old_p;

  always #4 clk = ~clk;

  rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .HIST_DEPTH(HD)) u0 (.*);

  int nvec = 0, nbad = 0;
  int mrat [NA];
  bit mfree [NP];
  bit hdst [HD]; int harch [HD], hnew [HD], hold [HD];
  int mhead = 0, mtail = 0, mcnt = 0;
  bit mflush = 0;

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (mfree[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit hd, input int d, input int s1, input int s2,
                      input bit cv, input bit fv, input string tag);
    bit er, acc, com, wk;
    int pk, e1, e2, eo, y;
    @(negedge clk);
    in_valid = iv; in_has_dst = hd; in_dst = AW'(d); in_src1 = AW'(s1); in_src2 = AW'(s2);
    commit_valid = cv; flush_valid = fv;
    #1;
    pk = lowest_free();
    er = !mflush && !fv && (mcnt < HD) && (!hd || pk >= 0);
    chk({tag, " in_ready"}, in_ready, er);
    acc = iv && er;
    com = cv && !mflush && !fv && mcnt > 0;
    wk  = mflush && mcnt > 0;
    e1 = mrat[s1]; e2 = mrat[s2]; eo = mrat[d];
    if (com) begin
      if (hdst[mhead]) mfree[hold[mhead]] = 1;
      mhead = (mhead + 1) % HD; mcnt--;
    end
    if (wk) begin
      y = (mtail + HD - 1) % HD;
      if (hdst[y]) begin mrat[harch[y]] = hold[y]; mfree[hnew[y]] = 1; end
      mtail = y; mcnt--;
    end
    if (acc) begin
      hdst[mtail] = hd; harch[mtail] = d; hnew[mtail] = pk; hold[mtail] = eo;
      if (hd) begin mrat[d] = pk; mfree[pk] = 0; end
      mtail = (mtail + 1) % HD; mcnt++;
    end
    if (fv) mflush = 1;
    else if (mflush && !wk) mflush = 0;
    @(posedge clk); #2;
    chk({tag, " out_valid"}, out_valid, acc);
    if (acc) begin
      chk({tag, " out_has_dst"}, out_has_dst, hd);
      chk({tag, " out_src1_p"}, out_src1_p, e1);
      chk({tag, " out_src2_p"}, out_src2_p, e2);
      chk({tag, " out_dst_p"}, out_dst_p, hd ? pk : 0);
      if (hd) chk({tag, " out_old_p"}, out_old_p, eo);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic drain_flush(input bit cv, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, tag);
    while (mflush) step(1, 1, 1, 2, 3, cv, 0, tag);
  endtask

  initial begin
    #(8ns * 200000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) mrat[i] = i;
    for (int i = 0; i < NP; i++) mfree[i] = (i >= NA);
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset out_valid", out_valid, 0);
    @(negedge clk); rst_n = 1;
    #1; chk("R1 reset in_ready", in_ready, 1);

    step(1, 1, 1, 2, 2, 0, 0, "R1 R3 first grant");
    chk("R1 first free tag", out_dst_p, NA);
    chk("R3 displaced tag", out_old_p, 1);
    step(1, 1, 3, 1, 1, 0, 0, "R4 read renamed");
    chk("R4 newest tag", out_src1_p, NA);
    step(1, 1, 1, 1, 2, 0, 0, "R2 same reg");
    chk("R2 old mapping seen", out_src1_p, NA);
    step(1, 0, 5, 3, 1, 0, 0, "R5 no dst");
    chk("R5 no tag", out_dst_p, 0);
    step(1, 1, 6, 5, 5, 0, 0, "R5 free set unchanged");
    chk("R5 next grant", out_dst_p, NA + 3);

    for (int k = 0; k < 6; k++) step(1, 1, k, k + 1, 7, 0, 0, "R3 fill");
    step(1, 1, 2, 0, 0, 0, 0, "R6 empty stall");
    step(1, 0, 2, 0, 4, 0, 0, "R6 no dst passes");
    step(1, 1, 4, 1, 1, 1, 0, "R9 commit with rename");
    step(1, 1, 4, 1, 1, 0, 0, "R9 freed next cycle");
    step(1, 1, 4, 4, 4, 1, 0, "R7 commit no dst entry");
    step(0, 0, 0, 0, 0, 1, 0, "R7 commit");
    step(1, 1, 0, 0, 0, 0, 0, "R7 reuse");

    drain_flush(1, "R8 flush walk");
    for (int i = 0; i < NA; i++) step(1, 0, 0, i, i, 0, 0, "R8 restored map");
    for (int k = 0; k < NA; k++) step(0, 0, 0, 0, 0, 1, 0, "R7 retire all");

    for (int k = 0; k < HD + 1; k++) step(1, 0, 0, k % NA, 0, 0, 0, "R10 fill history");
    step(1, 0, 0, 0, 0, 0, 0, "R10 full stall");
    step(1, 1, 3, 3, 3, 1, 0, "R10 commit frees slot");
    step(1, 0, 0, 3, 3, 0, 0, "R10 slot reused");
    drain_flush(0, "R8 flush full");

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) drain_flush(r == 0, "R8 random flush");
      else step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
                $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
                $urandom_range(0, NA - 1), $urandom_range(0, 2) == 0, 0, "R3 R7 R9 random");
    end

    idle("R1 tail");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule